// File: doc/BRIEF.md
# Dual-Resolution PWM Duty Generator

This block produces pulse-width-modulated outputs from a small file of byte-wide duty registers that a bus can write and read back. A single shared period counter advances on a clock-enable tick and each output is high while the counter is below that channel's duty value. The period is 255 ticks in narrow mode and 4095 ticks in wide mode. Neither is a power of two, so a full-scale duty gives a constant high and a zero duty gives a constant low.

In narrow mode each of the six byte registers sets the duty of its own output. In wide mode the registers are taken in pairs to form three 12-bit duties. A write to the odd register of a pair commits the pair: its low nibble and the byte already held in the even register form the new 12-bit value. Software therefore writes the even (low) register first. A new duty reaches the comparator only when the counter wraps to zero, so no truncated or stretched pulse appears.

Top module: `dualres_pwm`

## Requirements
- R1: After reset all six duty registers read 0x00, the counter is at 0 and every output is low.
- R2: A write to address 0..5 stores the full byte, including the upper nibble of an odd register, and a read of that address returns it. Addresses 6 and 7 read 0x00 and writes to them change no register.
- R3: With wide_mode=0, output i is high for exactly m of every 255 ticks, where m is register i. m=0 gives a constant low and m=255 gives a constant high.
- R4: With wide_mode=1, output k (k=0,1,2) is driven by the pair made of register 2k+1 (high) and register 2k (low). It is high for exactly m of every 4095 ticks, where m is the 12-bit pair value. Outputs 3 to 5 stay low.
- R5: Only bits 3:0 of the odd register form duty bits 11:8. Bits 7:4 have no effect on any output.
- R6: A pair's 12-bit duty changes only on a write to its odd register. It then takes the even register's current byte as bits 7:0. A write to the even register alone leaves the duty unchanged.
- R7: The counter runs from 0 to the last count (254 narrow, 4094 wide) and then wraps to 0. A duty written to the registers reaches an output only at that wrap.
- R8: The counter, and with it every output, changes only on cycles where tick=1. With tick held low the outputs are frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the duty registers |
| bus_addr | input | 3 | Register address; 0..5 valid |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| wide_mode | input | 1 | 0: six 8-bit channels; 1: three 12-bit channels |
| tick | input | 1 | Count enable for the period counter |
| pwm_out | output | 6 | PWM outputs |

## Verification
On every cycle the assertions check the counter mechanics: it holds without a tick, it returns to zero right after a wrap, and it never exceeds the wide last count. They also check that a channel's applied duty moves only at a wrap and that a pair's 12-bit value moves only on a write to its odd register. Duty ratios over a full period, the pairing map, the ignored upper nibble, write ordering and the exact wrap cycle at which a new duty first shows can only be shown by the bench's scenarios. The bench measures these by counting high samples at the pins over whole periods.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int BYTE_W = 8;
  localparam int HI_W   = 4;
  localparam int WIDE_W = BYTE_W + HI_W;
  localparam int NARROW_LAST = (1 << BYTE_W) - 2;
  localparam int WIDE_LAST   = (1 << WIDE_W) - 2;

  // last counter value of one period
  function automatic logic [WIDE_W-1:0] last_count(input logic wide);
    return wide ? WIDE_W'(WIDE_LAST) : WIDE_W'(NARROW_LAST);
  endfunction

  // 12-bit duty from a high nibble and a low byte
  function automatic logic [WIDE_W-1:0] duty_join(input logic [BYTE_W-1:0] hi,
                                                  input logic [BYTE_W-1:0] lo);
    return {hi[HI_W-1:0], lo};
  endfunction

  // output level for a counter value and a duty
  function automatic logic pwm_level(input logic [WIDE_W-1:0] cnt,
                                     input logic [WIDE_W-1:0] duty);
    return cnt < duty;
  endfunction
endpackage

// File: rtl/dpwm_regs.sv
module dpwm_regs
  import dpwm_pkg::*;
#(
  parameter int NCH = 6,
  localparam int NPAIR = NCH / 2,
  localparam int AW = $clog2(NCH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [AW-1:0]                addr,
  input  logic [BYTE_W-1:0]            wdata,
  output logic [BYTE_W-1:0]            rdata,
  output logic [NCH-1:0][BYTE_W-1:0]   regs_o,
  output logic [NPAIR-1:0][WIDE_W-1:0] wide_o
);
  logic [NCH-1:0][BYTE_W-1:0]   regs_q;
  logic [NPAIR-1:0][WIDE_W-1:0] wide_q;
  logic                         addr_ok;
  logic [NPAIR-1:0]             hi_wr;

  assign addr_ok = int'(addr) < NCH;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_q <= '0;
    else if (wr_en && addr_ok) regs_q[addr] <= wdata;
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign hi_wr[p] = wr_en && (addr == AW'(2 * p + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wide_q[p] <= '0;
      else if (hi_wr[p]) wide_q[p] <= duty_join(wdata, regs_q[2*p]);
    end

    // R6: the pair value moves only on a write to its odd register
    a_r6_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !hi_wr[p] |=> $stable(wide_q[p]));
  end

  always_comb begin
    rdata = '0;
    if (addr_ok) rdata = regs_q[addr];
  end

  assign regs_o = regs_q;
  assign wide_o = wide_q;
endmodule

// File: rtl/dpwm_counter.sv
module dpwm_counter
  import dpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wide,
  output logic [WIDE_W-1:0] cnt_o,
  output logic              wrap_o
);
  logic [WIDE_W-1:0] cnt_q;
  logic              wrap;

  // >= lets a mode switch from a long period wrap at once
  assign wrap = tick && (cnt_q >= last_count(wide));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap;

  // R8: no tick, no count
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  // R7: wrap lands on zero
  a_r7_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt_q == '0);
  // R7: never beyond the wide last count
  a_r7_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= WIDE_W'(WIDE_LAST));
endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel
  import dpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap,
  input  logic [WIDE_W-1:0] next_duty,
  input  logic [WIDE_W-1:0] cnt,
  output logic              out
);
  logic [WIDE_W-1:0] active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    active_q <= '0;
    else if (wrap) active_q <= next_duty;
  end

  assign out = pwm_level(cnt, active_q);

  // R7: applied duty changes only at a period wrap
  a_r7_apply_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(active_q));
endmodule

// File: rtl/dualres_pwm.sv
module dualres_pwm
  import dpwm_pkg::*;
#(
  parameter int NCH = 6,
  localparam int NPAIR = NCH / 2,
  localparam int AW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              wide_mode,
  input  logic              tick,
  output logic [NCH-1:0]    pwm_out
);
  logic [NCH-1:0][BYTE_W-1:0]   regs;
  logic [NPAIR-1:0][WIDE_W-1:0] wide_duty;
  logic [WIDE_W-1:0]            cnt;
  logic                         wrap;

  dpwm_regs #(.NCH(NCH)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .regs_o(regs), .wide_o(wide_duty)
  );

  dpwm_counter cnt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wide(wide_mode),
    .cnt_o(cnt), .wrap_o(wrap)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [WIDE_W-1:0] next_duty;
    if (i < NPAIR) begin : g_paired
      assign next_duty = wide_mode ? wide_duty[i] : WIDE_W'(regs[i]);
    end else begin : g_narrow_only
      assign next_duty = wide_mode ? '0 : WIDE_W'(regs[i]);
    end

    dpwm_channel ch_i (
      .clk(clk), .rst_n(rst_n), .wrap(wrap), .next_duty(next_duty),
      .cnt(cnt), .out(pwm_out[i])
    );
  end
endmodule

// File: tb/dualres_pwm_tb_top.sv
`timescale 1ns/1ps
module dualres_pwm_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       wide_mode = 1'b0;
  logic       tick = 1'b0;
  logic [5:0] pwm_out;

  logic run = 1'b0;
  logic gap = 1'b0;
  int   checks = 0;
  int   errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;
  always @(negedge clk) tick <= run && (!gap || !tick);

  dualres_pwm dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wide_mode(wide_mode),
    .tick(tick), .pwm_out(pwm_out)
  );

  // {wide[16], ch[15:13], unused, duty[11:0]}
  localparam logic [16:0] VEC [11] = '{
    {1'b0, 3'd0, 1'b0, 12'd0},   {1'b0, 3'd1, 1'b0, 12'd1},
    {1'b0, 3'd2, 1'b0, 12'd128}, {1'b0, 3'd3, 1'b0, 12'd254},
    {1'b0, 3'd4, 1'b0, 12'd255}, {1'b0, 3'd5, 1'b0, 12'd77},
    {1'b1, 3'd0, 1'b0, 12'h000}, {1'b1, 3'd1, 1'b0, 12'hFFF},
    {1'b1, 3'd2, 1'b0, 12'h800}, {1'b1, 3'd0, 1'b0, 12'h001},
    {1'b1, 3'd1, 1'b0, 12'hABC}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  // settle past one wrap, then count highs over `win` cycles
  task automatic measure(input int ch, input int per, input int win,
                         output int hi, output int upper_hi);
    hi = 0; upper_hi = 0;
    repeat (per + 2) @(negedge clk);
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
      if (pwm_out[5:3] != 3'b000) upper_hi++;
    end
  endtask

  initial begin
    int v, hi, up;
    logic [5:0] frozen;
    // R1: reset state
    run = 1'b1;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 6; a++) begin
      bus_addr = 3'(a);
      #1 check("R1 reset reg read", int'(bus_rdata), 0);
    end
    check("R1 outputs low in reset", int'(pwm_out), 0);

    // R7: duty written after reset shows first at the 255th tick edge
    @(negedge clk);
    rst_n = 1'b1;
    bus_addr = 3'd0; bus_wdata = 8'd200; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    repeat (252) @(posedge clk);
    @(negedge clk);
    check("R7 before wrap (cnt 253)", int'(pwm_out[0]), 0);
    @(posedge clk);
    @(negedge clk);
    check("R7 before wrap (cnt 254)", int'(pwm_out[0]), 0);
    @(posedge clk);
    @(negedge clk);
    check("R7 applied at wrap", int'(pwm_out[0]), 1);

    // R3/R4/R5 vector table
    foreach (VEC[n]) begin
      int ch, duty, per;
      ch = int'(VEC[n][15:13]);
      duty = int'(VEC[n][11:0]);
      @(negedge clk);
      wide_mode = VEC[n][16];
      if (VEC[n][16]) begin
        per = 4095;
        do_write(3'(2 * ch), duty[7:0]);
        do_write(3'(2 * ch + 1), {4'hC, duty[11:8]});
        measure(ch, per, per, hi, up);
        check("R4 wide duty high count", hi, duty);
        check("R4 outputs 3..5 low in wide mode", up, 0);
      end else begin
        per = 255;
        do_write(3'(ch), duty[7:0]);
        measure(ch, per, per, hi, up);
        check("R3 narrow duty high count", hi, duty);
      end
    end

    // R5/R2: upper nibble ignored for duty, kept for readback
    wide_mode = 1'b1;
    do_write(3'd2, 8'h21);
    do_write(3'd3, 8'hF3);
    do_read(3'd3, v);
    check("R2 odd register readback keeps upper nibble", v, 8'hF3);
    measure(1, 4095, 4095, hi, up);
    check("R5 upper nibble ignored", hi, 12'h321);

    // R6: low write alone has no effect; high-before-low uses old low
    do_write(3'd2, 8'h55);
    measure(1, 4095, 4095, hi, up);
    check("R6 low write alone no effect", hi, 12'h321);
    do_write(3'd3, 8'h02);
    do_write(3'd2, 8'h10);
    measure(1, 4095, 4095, hi, up);
    check("R6 pair takes low byte held at high write", hi, 12'h255);

    // R2: out-of-range addresses
    do_write(3'd6, 8'hEE);
    do_write(3'd7, 8'hDD);
    do_read(3'd6, v);
    check("R2 address 6 reads zero", v, 0);
    do_read(3'd7, v);
    check("R2 address 7 reads zero", v, 0);
    do_read(3'd2, v);
    check("R2 reg2 unchanged by bad address", v, 8'h10);
    do_read(3'd5, v);
    check("R2 reg5 unchanged by bad address", v, 8'hC8);

    // R8: half-rate tick doubles the window; tick low freezes outputs
    wide_mode = 1'b0;
    do_write(3'd0, 8'd100);
    gap = 1'b1;
    measure(0, 510, 510, hi, up);
    check("R8 half-rate tick high count", hi, 200);
    gap = 1'b0;
    run = 1'b0;
    @(negedge clk);
    @(negedge clk);
    frozen = pwm_out;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (pwm_out != frozen) up = -1;
    end
    check("R8 outputs frozen without tick", int'(pwm_out), int'(frozen));
    run = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule